// File: doc/BRIEF.md
# Delayed Transaction Discard Timer

This block governs the lifetime of a single delayed read or write completion parked in a bridge buffer. When the completion data lands in the buffer, the entry becomes valid and a timeout window opens. The requesting master is expected to come back and repeat its request. If that retry is seen while the entry is held, the data is handed over. If the window closes first, the entry is dropped.

The window is deliberately coarse. One free-running prescaler serves every entry and produces two tap ticks, a short one and a long one. Each entry counts only ticks of the tap chosen when it started, and it expires on the second such tick. The real delay therefore falls somewhere within a power-of-two range.

A secondary bus reset returns the entry to idle without raising any indication. Request matching, buffer storage and bus signalling are handled by the surrounding logic.

Top module: `dt_discard_timer`

## Requirements
- R1: While rst_ni is low and after it is released, valid_o, discard_o and delivered_o are 0 until a ready strobe is accepted.
- R2: ready_i sampled high while the entry is idle and bus_rst_i is low makes valid_o 1 after that clock edge. The same edge latches short_sel_i, where 1 selects the short window and 0 the long window.
- R3: The prescaler starts at 0 when reset is released and advances on every edge. Counting edges from 0 after release, a short tick falls on edge k when k mod 2^SHORT_EXP = 2^SHORT_EXP-1, and a long tick falls on edge k when k mod 2^LONG_EXP = 2^LONG_EXP-1. A held entry expires on the second tick of its latched tap strictly after its start edge. The start-to-expiry distance is therefore greater than 2^N and at most 2^(N+1) edges (N = 10 short, 15 long).
- R4: On expiry, discard_o is 1 for exactly one cycle and valid_o is 0 from that same edge.
- R5: hit_i sampled high while the entry is held gives a one-cycle delivered_o pulse, and valid_o drops on the same edge. hit_i while idle changes no output.
- R6: A hit sampled on the expiry edge counts as a hit: delivered_o pulses and discard_o stays 0.
- R7: ready_i while the entry is held is ignored. valid_o stays 1 and the expiry edge does not move.
- R8: bus_rst_i sampled high returns the entry to idle with no pulse on either output. It takes priority over hit_i and ready_i on the same edge and does not disturb the prescaler phase.
- R9: Changing short_sel_i while the entry is held has no effect on its expiry edge.
- R10: discard_o and delivered_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Completion data has been placed in the buffer |
| hit_i | input | 1 | Master repeated the matching request |
| short_sel_i | input | 1 | Timeout range select, 1 short, 0 long |
| bus_rst_i | input | 1 | Secondary bus reset, synchronous |
| valid_o | output | 1 | Entry holds an unclaimed completion |
| discard_o | output | 1 | One-cycle pulse, entry expired unclaimed |
| delivered_o | output | 1 | One-cycle pulse, retry consumed the entry |

## Verification
A tick counter that is wrong, or a tap select that is latched wrongly, moves the discard pulse by a whole prescaler period. The move is 1024 or 32768 edges, and it shows up in the first expiry after the fault. A prescaler phase that has been disturbed by a bus reset shows up the same way on the next timed entry. A state register that fails to leave the held state shows up within one edge, either as valid_o staying high after a pulse or as a missing pulse when a hit arrives. Comparing all three outputs against the model on every edge exposes each of these faults at the first edge where the outputs diverge.

// File: rtl/dt_discard_pkg.sv
package dt_discard_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HELD = 1'b1
  } entry_state_e;
endpackage

// File: rtl/dt_prescaler.sv
module dt_prescaler #(
  parameter int unsigned SHORT_EXP = 10,
  parameter int unsigned LONG_EXP  = 15
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_short_o,
  output logic tick_long_o
);
  localparam int unsigned CW = LONG_EXP;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(1);
  end

  // tick on the last count of each tap period
  assign tick_short_o = &cnt_q[SHORT_EXP-1:0];
  assign tick_long_o  = &cnt_q;
endmodule

// File: rtl/dt_entry.sv
module dt_entry
  import dt_discard_pkg::*;
#(
  parameter int unsigned EXPIRE_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic hit_i,
  input  logic short_sel_i,
  input  logic bus_rst_i,
  input  logic tick_short_i,
  input  logic tick_long_i,
  output logic valid_o,
  output logic discard_o,
  output logic delivered_o
);
  localparam int unsigned TCW = (EXPIRE_TICKS > 1) ? $clog2(EXPIRE_TICKS) : 1;
  localparam logic [TCW-1:0] LAST_CNT = TCW'(EXPIRE_TICKS - 1);

  entry_state_e   state_q;
  logic           sel_q;
  logic [TCW-1:0] tcnt_q;
  logic           discard_q, deliv_q;
  logic           tick_sel, last_tick;

  assign tick_sel  = sel_q ? tick_short_i : tick_long_i;
  assign last_tick = tick_sel && (tcnt_q == LAST_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      sel_q     <= 1'b0;
      tcnt_q    <= '0;
      discard_q <= 1'b0;
      deliv_q   <= 1'b0;
    end else begin
      discard_q <= 1'b0;
      deliv_q   <= 1'b0;
      if (bus_rst_i) begin
        state_q <= ST_IDLE;
        tcnt_q  <= '0;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (ready_i) begin
              state_q <= ST_HELD;
              sel_q   <= short_sel_i;
              tcnt_q  <= '0;
            end
          end
          ST_HELD: begin
            // hit wins over expiry on the same edge
            if (hit_i) begin
              deliv_q <= 1'b1;
              state_q <= ST_IDLE;
            end else if (last_tick) begin
              discard_q <= 1'b1;
              state_q   <= ST_IDLE;
            end else if (tick_sel) begin
              tcnt_q <= tcnt_q + TCW'(1);
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign valid_o     = (state_q == ST_HELD);
  assign discard_o   = discard_q;
  assign delivered_o = deliv_q;
endmodule

// File: rtl/dt_discard_timer.sv
module dt_discard_timer #(
  parameter int unsigned SHORT_EXP    = 10,
  parameter int unsigned LONG_EXP     = 15,
  parameter int unsigned EXPIRE_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic hit_i,
  input  logic short_sel_i,
  input  logic bus_rst_i,
  output logic valid_o,
  output logic discard_o,
  output logic delivered_o
);
  logic tick_short, tick_long;

  dt_prescaler #(
    .SHORT_EXP(SHORT_EXP),
    .LONG_EXP (LONG_EXP)
  ) u_presc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_short_o(tick_short),
    .tick_long_o (tick_long)
  );

  dt_entry #(
    .EXPIRE_TICKS(EXPIRE_TICKS)
  ) u_entry (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ready_i     (ready_i),
    .hit_i       (hit_i),
    .short_sel_i (short_sel_i),
    .bus_rst_i   (bus_rst_i),
    .tick_short_i(tick_short),
    .tick_long_i (tick_long),
    .valid_o     (valid_o),
    .discard_o   (discard_o),
    .delivered_o (delivered_o)
  );
endmodule

// File: rtl/dt_discard_timer_chk.sv
module dt_discard_timer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_i,
  input logic hit_i,
  input logic bus_rst_i,
  input logic valid_o,
  input logic discard_o,
  input logic delivered_o
);
  a_r2_start_accepted: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && ready_i && !bus_rst_i) |=> valid_o);

  a_r4_discard_clears_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |-> !valid_o);

  a_r4_discard_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |=> !discard_o);

  a_r5_deliver_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delivered_o |=> !delivered_o);

  a_r6_hit_delivers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && hit_i && !bus_rst_i) |=> (delivered_o && !discard_o && !valid_o));

  a_r8_bus_reset_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_i |=> (!valid_o && !discard_o && !delivered_o));

  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(discard_o && delivered_o));
endmodule

bind dt_discard_timer dt_discard_timer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_i    (ready_i),
  .hit_i      (hit_i),
  .bus_rst_i  (bus_rst_i),
  .valid_o    (valid_o),
  .discard_o  (discard_o),
  .delivered_o(delivered_o)
);

// File: tb/dt_discard_timer_bench.sv
`timescale 1ns/1ps
module dt_discard_timer_bench;
  localparam int SHORT_P = 1024;
  localparam int LONG_P  = 32768;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ready_i = 1'b0, hit_i = 1'b0, short_sel_i = 1'b0, bus_rst_i = 1'b0;
  logic valid_o, discard_o, delivered_o;

  always #2.5 clk = ~clk;

  dt_discard_timer u_dt_discard_timer (
    .clk_i(clk), .rst_ni(rst_ni), .ready_i(ready_i), .hit_i(hit_i),
    .short_sel_i(short_sel_i), .bus_rst_i(bus_rst_i),
    .valid_o(valid_o), .discard_o(discard_o), .delivered_o(delivered_o)
  );

  int compared = 0, mismatched = 0;
  int cyc = 0;
  bit m_valid = 0, m_disc = 0, m_deliv = 0, m_sel = 0;
  int m_ticks = 0;
  int last_disc_edge = -1, last_deliv_edge = -1;
  bit done = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // behavioural reference, updated from inputs sampled at each edge
  always @(posedge clk) begin
    if (!rst_ni) begin
      cyc = 0; m_valid = 0; m_disc = 0; m_deliv = 0; m_ticks = 0; m_sel = 0;
    end else begin
      bit ts, tl, tk;
      ts = (cyc % SHORT_P) == SHORT_P - 1;
      tl = (cyc % LONG_P) == LONG_P - 1;
      m_disc = 0; m_deliv = 0;
      if (bus_rst_i) begin
        m_valid = 0; m_ticks = 0;
      end else if (m_valid) begin
        tk = m_sel ? ts : tl;
        if (hit_i) begin m_deliv = 1; m_valid = 0; end
        else if (tk && m_ticks == 1) begin m_disc = 1; m_valid = 0; end
        else if (tk) m_ticks++;
      end else if (ready_i) begin
        m_valid = 1; m_sel = short_sel_i; m_ticks = 0;
      end
      cyc++;
    end
    #1;
    if (!done) begin
      check(valid_o == m_valid, "R2/R5/R7/R8 valid_o", valid_o, m_valid);
      check(discard_o == m_disc, "R3/R4/R6/R9 discard_o", discard_o, m_disc);
      check(delivered_o == m_deliv, "R5/R6/R8 delivered_o", delivered_o, m_deliv);
      if (discard_o) last_disc_edge = cyc - 1;
      if (delivered_o) last_deliv_edge = cyc - 1;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL R3 watchdog expired actual=%0d expected<200000", cyc);
    finish_run();
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns the edge index at which ready is sampled
  task automatic start(input bit sel, output int s);
    @(negedge clk);
    ready_i = 1; short_sel_i = sel; s = cyc;
    @(negedge clk);
    ready_i = 0;
  endtask

  function automatic int expiry_edge(input int s, input int p);
    int t1;
    t1 = s + (p - 1 - (s % p));
    if (t1 == s) t1 += p;
    return t1 + p;
  endfunction

  task automatic wait_edge(input int e);
    while (cyc <= e) @(negedge clk);
  endtask

  initial begin
    int s, e;
    step(3);
    check(valid_o == 0 && discard_o == 0 && delivered_o == 0, "R1 outputs in reset", valid_o, 0);
    rst_ni = 1;
    step(2);
    check(valid_o == 0, "R1 idle after release", valid_o, 0);

    // R2 R3 R4 short expiry
    start(1, s);
    check(valid_o == 1, "R2 valid after ready", valid_o, 1);
    e = expiry_edge(s, SHORT_P);
    wait_edge(e);
    check(last_disc_edge == e, "R3 short expiry edge", last_disc_edge, e);
    check(e - s > SHORT_P && e - s <= 2 * SHORT_P, "R3 short range", e - s, SHORT_P);
    step(1);
    check(discard_o == 0 && valid_o == 0, "R4 single pulse", discard_o, 0);

    // R5 hit while idle ignored, then hit while held
    hit_i = 1; step(1); hit_i = 0; step(1);
    check(delivered_o == 0 && valid_o == 0, "R5 idle hit ignored", delivered_o, 0);
    start(1, s);
    step(100);
    hit_i = 1; e = cyc; step(1); hit_i = 0; step(1);
    check(last_deliv_edge == e, "R5 delivered edge", last_deliv_edge, e);

    // R7 ready while held ignored
    start(1, s);
    e = expiry_edge(s, SHORT_P);
    step(300);
    ready_i = 1; short_sel_i = 0; step(1); ready_i = 0;
    wait_edge(e);
    check(last_disc_edge == e, "R7 expiry unchanged", last_disc_edge, e);

    // R9 select flip mid-flight
    start(1, s);
    e = expiry_edge(s, SHORT_P);
    step(5); short_sel_i = 0;
    wait_edge(e);
    check(last_disc_edge == e, "R9 latched select", last_disc_edge, e);

    // R6 hit on expiry edge
    start(1, s);
    e = expiry_edge(s, SHORT_P);
    while (cyc != e) @(negedge clk);
    hit_i = 1; step(1); hit_i = 0; step(1);
    check(last_deliv_edge == e, "R6 hit on expiry delivers", last_deliv_edge, e);
    check(last_disc_edge != e, "R6 no discard on expiry hit", last_disc_edge, -1);

    // R8 bus reset with hit and ready on the same edge
    start(1, s);
    step(50);
    bus_rst_i = 1; hit_i = 1; ready_i = 1; e = cyc; step(1);
    bus_rst_i = 0; hit_i = 0; ready_i = 0; step(1);
    check(valid_o == 0 && last_deliv_edge != e, "R8 bus reset quiet", valid_o, 0);
    // prescaler phase unaffected
    start(1, s);
    e = expiry_edge(s, SHORT_P);
    wait_edge(e);
    check(last_disc_edge == e, "R8 prescaler phase kept", last_disc_edge, e);

    // R10 back-to-back restart after delivery
    start(1, s);
    step(10); hit_i = 1; step(1); hit_i = 0;
    start(1, s);
    check(valid_o == 1, "R10 restart after delivery", valid_o, 1);
    hit_i = 1; step(1); hit_i = 0; step(1);

    // R3 long range
    start(0, s);
    e = expiry_edge(s, LONG_P);
    wait_edge(e);
    check(last_disc_edge == e, "R3 long expiry edge", last_disc_edge, e);
    check(e - s > LONG_P && e - s <= 2 * LONG_P, "R3 long range", e - s, LONG_P);
    step(3);
    finish_run();
  end
endmodule